// File: doc/BRIEF.md
# Logarithmic-Depth Running Parity Scanner

This block takes an N-bit word and returns, at every bit position, the parity of that bit and all bits below it. Bit 0 is passed straight through. The top bit carries the parity of the whole word.

The block is purely combinational and has no clock. A result therefore appears in the same cycle as its operand, and the surrounding logic decides whether to register it. There is no stream traffic here, so there is no valid/ready handshake.

The work is done by a prefix network with ceil(log2 N) levels. At level k, every position at or above 2^k combines its running value with the running value 2^k places below it. Positions below 2^k keep their value unchanged. Partial parities are thus reused by all outputs, so the design needs neither a ripple chain nor one reduction tree per output. The width N defaults to 8 and may be any value of at least 1, including values that are not powers of two.

Top module: `xpfx_scan`

## Requirements
- R1: For every position i, out_par[i] equals the XOR of in_bits[0] through in_bits[i].
- R2: out_par[0] equals in_bits[0].
- R3: out_par[N-1] equals the parity (XOR of all bits) of in_bits.
- R4: R1 holds for widths that are not powers of two (checked at N=13) as well as for the default N=8.
- R5: Inverting a single input bit j inverts exactly out_par[j] through out_par[N-1] and leaves all lower output bits unchanged.
- R6: An all-zero input gives an all-zero output. An all-ones input gives 1 at even positions and 0 at odd positions (position 0 is even).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_bits | input | N | Operand word; bit 0 is the start of the scan |
| out_par | output | N | Running parity; bit i covers in_bits[i:0] |

## Verification
The bound checker tests, whenever the operand changes, that each pair of neighbouring outputs differs exactly by the matching input bit, that the lowest output equals the lowest input, that the top output equals the word parity, and that a zero operand gives a zero result. Bench scenarios are needed for the rest. Exhaustive sweeps at an odd width show that the network has no gap at ragged widths. Paired single-bit flips show that a change only reaches the outputs at and above the flipped position. The all-ones pattern shows the alternating output.

// File: rtl/xpfx_pkg.sv
package xpfx_pkg;
  // Number of prefix levels needed for a word of n bits.
  function automatic int unsigned xpfx_levels(input int unsigned n);
    int unsigned lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    return lv;
  endfunction
endpackage

// File: rtl/xpfx_cell.sv
module xpfx_cell (
  input  logic own_bit,
  input  logic far_bit,
  output logic merged
);
  assign merged = own_bit ^ far_bit;
endmodule

// File: rtl/xpfx_stage.sv
module xpfx_stage #(
  parameter int unsigned N    = 8,
  parameter int unsigned DIST = 1
) (
  input  logic [N-1:0] lvl_in,
  output logic [N-1:0] lvl_out
);
  for (genvar i = 0; i < N; i++) begin : g_pos
    if (i >= DIST) begin : g_merge
      xpfx_cell u_cell (
        .own_bit (lvl_in[i]),
        .far_bit (lvl_in[i-DIST]),
        .merged  (lvl_out[i])
      );
    end else begin : g_pass
      assign lvl_out[i] = lvl_in[i];
    end
  end
endmodule

// File: rtl/xpfx_scan.sv
module xpfx_scan
  import xpfx_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] in_bits,
  output logic [N-1:0] out_par
);
  localparam int unsigned LEVELS = xpfx_levels(N);

  logic [LEVELS:0][N-1:0] lvl;

  assign lvl[0] = in_bits;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    xpfx_stage #(
      .N    (N),
      .DIST (1 << k)
    ) u_stage (
      .lvl_in  (lvl[k]),
      .lvl_out (lvl[k+1])
    );
  end

  assign out_par = lvl[LEVELS];
endmodule

// File: rtl/xpfx_scan_chk.sv
module xpfx_scan_chk #(
  parameter int unsigned N = 8
) (
  input logic [N-1:0] in_bits,
  input logic [N-1:0] out_par
);
  always_comb begin
    if (!$isunknown(in_bits)) begin
      AST_FIRST_BIT: assert (out_par[0] == in_bits[0])
        else $error("first bit mismatch"); // R2
      AST_WORD_PARITY: assert (out_par[N-1] == ^in_bits)
        else $error("top bit is not word parity"); // R3
      AST_ZERO_WORD: assert (in_bits != '0 || out_par == '0)
        else $error("zero input gave nonzero output"); // R6
    end
  end

  for (genvar i = 1; i < N; i++) begin : g_link
    always_comb begin
      if (!$isunknown(in_bits)) begin
        AST_NEIGHBOR_STEP: assert ((out_par[i] ^ out_par[i-1]) == in_bits[i])
          else $error("step mismatch at %0d", i); // R1
      end
    end
  end
endmodule

bind xpfx_scan xpfx_scan_chk #(.N(N)) u_chk (
  .in_bits (in_bits),
  .out_par (out_par)
);

// File: tb/sim_xpfx_scan.sv
module sim_xpfx_scan;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [7:0]  a8  = '0;
  logic [7:0]  y8;
  logic [12:0] a13 = '0;
  logic [12:0] y13;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  xpfx_scan #(.N(8))  u0 (.in_bits(a8),  .out_par(y8));
  xpfx_scan #(.N(13)) u1 (.in_bits(a13), .out_par(y13));

  // Serial reference: running parity, one bit at a time.
  function automatic logic [31:0] ref_scan(input logic [31:0] v, input int n);
    logic [31:0] r;
    logic acc;
    r = '0;
    acc = 1'b0;
    for (int i = 0; i < n; i++) begin
      acc = acc ^ v[i];
      r[i] = acc;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [12:0] v);
    @(negedge clk);
    a8  = v[7:0];
    a13 = v;
    @(posedge clk);
    #1;
  endtask

  task automatic compare_all(input logic [12:0] v);
    logic [31:0] e8, e13;
    e8  = ref_scan({24'd0, v[7:0]}, 8);
    e13 = ref_scan({19'd0, v}, 13);
    chk("R1 full scan N=8", {24'd0, y8}, e8);
    chk("R4 full scan N=13", {19'd0, y13}, e13);
    chk("R2 bit0", {31'd0, y8[0]}, {31'd0, v[0]});
    chk("R3 parity N=13", {31'd0, y13[12]}, {31'd0, ^v});
  endtask

  initial begin
    logic [12:0] v;
    logic [12:0] base_y;
    logic [12:0] mask;
    // reset state: zero operand
    drive(13'd0);
    chk("R6 zero input N=8", {24'd0, y8}, 32'd0);
    chk("R6 zero input N=13", {19'd0, y13}, 32'd0);
    // all ones
    drive(13'h1FFF);
    chk("R6 all ones N=8", {24'd0, y8}, 32'h55);
    chk("R6 all ones N=13", {19'd0, y13}, 32'h1555);
    // exhaustive over 13 bits (covers every 8-bit word too)
    for (int n = 0; n < 8192; n++) begin
      v = 13'(n);
      drive(v);
      compare_all(v);
    end
    // random patterns
    for (int n = 0; n < 300; n++) begin
      v = 13'($urandom);
      drive(v);
      compare_all(v);
    end
    // single-bit flips
    for (int n = 0; n < 20; n++) begin
      v = 13'($urandom);
      for (int j = 0; j < 13; j++) begin
        drive(v);
        base_y = y13;
        drive(v ^ (13'd1 << j));
        mask = 13'h1FFF << j;
        chk("R5 flip reach", {19'd0, base_y ^ y13}, {19'd0, mask});
      end
    end
    done = 1'b1;
  end

  initial begin : watchdog
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule